// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Address Filter

This block is the receive half of a byte-oriented asynchronous serial port running with a ninth data bit. It watches the serial line for a high-to-low transition. It times every bit against a sample enable that pulses sixteen times per bit period. Each bit is settled by a vote of three samples taken at the middle of the bit. A frame is a start bit, eight data bits sent least significant bit first, a ninth bit and a stop bit.

The ninth bit lets several nodes share one line. Bytes with the ninth bit high carry an address and bytes with it low carry data. When address filtering is on, the receive flag is raised only for an address that hits this node's own address or the broadcast address, so software is never woken for traffic meant for others. A missing stop bit sets a sticky framing-error flag. That flag shares bit 7 of the control register with a stored mode bit, and a select input decides which of the two is read or written there.

The control-register write data uses this layout: bit 7 is the shared mode/error bit, bit 5 enables address filtering, bit 4 enables reception, bit 0 is the receive flag. The read data also shows the received ninth bit at bit 2, and all other bits read 0. The FSM has four states. ST_IDLE moves to ST_START on a falling edge while reception is enabled. ST_START returns to ST_IDLE if the start bit votes high (abort), and otherwise moves to ST_SHIFT at the end of the bit. ST_SHIFT moves to ST_STOP once nine bits are collected. ST_STOP returns to ST_IDLE when the stop bit is voted, and pulses a frame-complete strobe at that point.

Top module: `mpuart_rx`

## Requirements
- R1: After reset, ri, fe, rx_bit9 and rx_data are 0 and ctl_rdata reads 8'h00.
- R2: Reception starts only on a high-to-low transition of rx_line while the enable bit (write bit 4) is 1. With it 0, a whole frame leaves ri at 0 and rx_data unchanged.
- R3: Each bit is decided by a majority of samples at ticks 7, 8 and 9 of its 16. If the start bit votes high, the receiver returns to idle without raising any flag, and a following valid frame is still received.
- R4: An accepted frame loads rx_data with the eight data bits (first received bit in bit 0) and rx_bit9 with the ninth bit, and sets ri.
- R5: With address filtering off (write bit 5 = 0), every completed frame is accepted while ri is 0, whatever its ninth bit.
- R6: With filtering on, a ninth bit of 0 never raises ri. A ninth bit of 1 raises ri only when (byte AND addr_mask) equals (own_addr AND addr_mask), or when the byte has a 1 in every bit that is 1 in (own_addr OR addr_mask). A filtered frame leaves rx_data unchanged.
- R7: While ri is 1, a further frame leaves rx_data, rx_bit9 and ri unchanged.
- R8: A stop bit sampled as 0 sets fe, whether or not the frame is accepted.
- R9: fe is sticky. Later good frames leave it set. It is cleared only by a control write with sel_fe = 1 and bit 7 = 0, and a write of 1 never sets it.
- R10: With sel_fe = 0, bit 7 writes and reads go to the stored mode bit and fe is untouched. With sel_fe = 1, ctl_rdata bit 7 shows fe.
- R11: ctl_rdata shows filter enable at bit 5, receive enable at bit 4, rx_bit9 at bit 2 and ri at bit 0. A write of bit 0 sets ri to the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial receive line, idle high |
| tick16 | input | 1 | One-cycle pulse, 16 per bit period |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| sel_fe | input | 1 | Bit 7 select: 1 = error flag, 0 = mode bit |
| own_addr | input | 8 | Node address |
| addr_mask | input | 8 | Address compare mask |
| ctl_rdata | output | 8 | Control register read data |
| rx_data | output | 8 | Received byte |
| rx_bit9 | output | 1 | Received ninth bit |
| ri | output | 1 | Receive flag |
| fe | output | 1 | Sticky framing-error flag |

## Verification
Some rules are checked by assertions on every cycle: fe rises only after a frame with a bad stop bit, and falls only after a clearing write with the select high. Held data stays stable while ri is set. A filtered data byte never raises ri, and ri never rises by hardware without a completed frame. Other behaviours need whole serial frames and can only be shown by bench scenarios: the start-bit abort and resynchronisation, the given-address and broadcast matches, the select routing of bit 7, and the byte and ninth-bit values that end up in the holding registers.

// File: rtl/mpuart_rx_pkg.sv
package mpuart_rx_pkg;
    localparam int DATA_W  = 8;
    localparam int OS_RATE = 16;

    // control register field positions
    localparam int CB_SHARED = 7;
    localparam int CB_MPEN   = 5;
    localparam int CB_RXEN   = 4;
    localparam int CB_BIT9   = 2;
    localparam int CB_RI     = 0;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_SHIFT,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              bit9;
        logic              stop_ok;
    } rx_frame_t;
endpackage

// File: rtl/mpuart_bit_sampler.sv
module mpuart_bit_sampler #(
    parameter int OS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_line,
    input  logic tick,
    input  logic restart,
    output logic fall,
    output logic bit_val,
    output logic vote_strobe,
    output logic bit_end
);
    localparam int CW = $clog2(OS);
    localparam logic [CW-1:0] P_A   = CW'(OS/2 - 1);
    localparam logic [CW-1:0] P_B   = CW'(OS/2);
    localparam logic [CW-1:0] P_C   = CW'(OS/2 + 1);
    localparam logic [CW-1:0] P_END = CW'(OS - 1);

    logic [1:0]    sync_q;
    logic          prev_q;
    logic          smp_a, smp_b;
    logic [CW-1:0] phase;
    logic [CW-1:0] cur;
    logic          rx_s;

    assign rx_s = sync_q[1];
    assign cur  = phase + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            prev_q <= 1'b1;
            phase  <= '0;
            smp_a  <= 1'b1;
            smp_b  <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], rx_line};
            if (tick) begin
                prev_q <= rx_s;
                phase  <= restart ? '0 : cur;
                if (cur == P_A) smp_a <= rx_s;
                if (cur == P_B) smp_b <= rx_s;
            end
        end
    end

    assign fall        = tick && prev_q && !rx_s;
    assign bit_val     = (smp_a & smp_b) | (smp_a & rx_s) | (smp_b & rx_s);
    assign vote_strobe = tick && (cur == P_C);
    assign bit_end     = tick && (cur == P_END);
endmodule

// File: rtl/mpuart_rx_fsm.sv
module mpuart_rx_fsm
    import mpuart_rx_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rx_en,
    input  logic      fall,
    input  logic      bit_val,
    input  logic      vote_strobe,
    input  logic      bit_end,
    output logic      restart,
    output logic      frame_done,
    output rx_frame_t frame
);
    localparam int NBITS = DW + 1;
    localparam int IW    = $clog2(NBITS + 1);
    localparam logic [IW-1:0] LAST = IW'(NBITS);

    rx_state_e     state, state_nx;
    logic [IW-1:0] bit_idx;
    logic [DW:0]   shreg;

    assign restart = (state == ST_IDLE) && fall && rx_en;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (restart) state_nx = ST_START;
            ST_START: begin
                if (vote_strobe && bit_val) state_nx = ST_IDLE;
                else if (bit_end)           state_nx = ST_SHIFT;
            end
            ST_SHIFT: if (bit_end && bit_idx == LAST) state_nx = ST_STOP;
            ST_STOP:  if (vote_strobe) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx    <= '0;
            shreg      <= '0;
            frame_done <= 1'b0;
            frame      <= '0;
        end else begin
            frame_done <= 1'b0;
            unique case (state)
                ST_IDLE:  bit_idx <= '0;
                ST_START: bit_idx <= '0;
                ST_SHIFT: if (vote_strobe) begin
                    shreg   <= {bit_val, shreg[DW:1]};
                    bit_idx <= bit_idx + 1'b1;
                end
                ST_STOP:  if (vote_strobe) begin
                    frame_done    <= 1'b1;
                    frame.data    <= shreg[DW-1:0];
                    frame.bit9    <= shreg[DW];
                    frame.stop_ok <= bit_val;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mpuart_addr_filter.sv
module mpuart_addr_filter #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] rx_byte,
    input  logic [DW-1:0] own_addr,
    input  logic [DW-1:0] addr_mask,
    output logic          hit
);
    logic [DW-1:0] bcast;
    logic          given_hit, bcast_hit;

    assign bcast     = own_addr | addr_mask;
    assign given_hit = (rx_byte & addr_mask) == (own_addr & addr_mask);
    assign bcast_hit = (rx_byte & bcast) == bcast;
    assign hit       = given_hit || bcast_hit;
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
    import mpuart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic              tick16,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_wdata,
    input  logic              sel_fe,
    input  logic [DATA_W-1:0] own_addr,
    input  logic [DATA_W-1:0] addr_mask,
    output logic [7:0]        ctl_rdata,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              ri,
    output logic              fe
);
    logic      fall, bit_val, vote_strobe, bit_end, restart;
    logic      frm_done, frm_stop_ok, frm_bit9, addr_hit, accept;
    logic      mp_en, rx_en, sm0;
    rx_frame_t frm;

    mpuart_bit_sampler #(.OS(OS_RATE)) u_smp (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick(tick16),
        .restart(restart), .fall(fall), .bit_val(bit_val),
        .vote_strobe(vote_strobe), .bit_end(bit_end)
    );

    mpuart_rx_fsm #(.DW(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .fall(fall),
        .bit_val(bit_val), .vote_strobe(vote_strobe), .bit_end(bit_end),
        .restart(restart), .frame_done(frm_done), .frame(frm)
    );

    mpuart_addr_filter #(.DW(DATA_W)) u_flt (
        .rx_byte(frm.data), .own_addr(own_addr), .addr_mask(addr_mask),
        .hit(addr_hit)
    );

    assign frm_stop_ok = frm.stop_ok;
    assign frm_bit9    = frm.bit9;
    assign accept      = !ri && (!mp_en || (frm_bit9 && addr_hit));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mp_en   <= 1'b0;
            rx_en   <= 1'b0;
            sm0     <= 1'b0;
            fe      <= 1'b0;
            ri      <= 1'b0;
            rx_data <= '0;
            rx_bit9 <= 1'b0;
        end else begin
            if (ctl_wr) begin
                mp_en <= ctl_wdata[CB_MPEN];
                rx_en <= ctl_wdata[CB_RXEN];
                ri    <= ctl_wdata[CB_RI];
                if (sel_fe) fe  <= fe & ctl_wdata[CB_SHARED];
                else        sm0 <= ctl_wdata[CB_SHARED];
            end
            if (frm_done) begin
                if (!frm_stop_ok) fe <= 1'b1;
                if (accept) begin
                    ri      <= 1'b1;
                    rx_data <= frm.data;
                    rx_bit9 <= frm_bit9;
                end
            end
        end
    end

    always_comb begin
        ctl_rdata            = '0;
        ctl_rdata[CB_SHARED] = sel_fe ? fe : sm0;
        ctl_rdata[CB_MPEN]   = mp_en;
        ctl_rdata[CB_RXEN]   = rx_en;
        ctl_rdata[CB_BIT9]   = rx_bit9;
        ctl_rdata[CB_RI]     = ri;
    end
endmodule

// File: rtl/mpuart_rx_chk.sv
module mpuart_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr,
    input logic [7:0] ctl_wdata,
    input logic       sel_fe,
    input logic       fe,
    input logic       ri,
    input logic [7:0] rx_data,
    input logic       rx_bit9,
    input logic       frm_done,
    input logic       frm_stop_ok,
    input logic       frm_bit9,
    input logic       mp_en
);
    // R9
    fe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fe) |-> $past(ctl_wr && sel_fe && !ctl_wdata[7]));

    // R8
    fe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fe) |-> $past(frm_done && !frm_stop_ok));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ri |=> ($stable(rx_data) && $stable(rx_bit9)));

    // R6
    mp_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && mp_en && !frm_bit9 && !ctl_wr) |=> !$rose(ri));

    // R4
    ri_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ri) && !$past(ctl_wr)) |-> $past(frm_done));
endmodule

bind mpuart_rx mpuart_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .sel_fe(sel_fe), .fe(fe), .ri(ri), .rx_data(rx_data), .rx_bit9(rx_bit9),
    .frm_done(frm_done), .frm_stop_ok(frm_stop_ok), .frm_bit9(frm_bit9),
    .mp_en(mp_en)
);

// File: tb/mpuart_rx_test.sv
module mpuart_rx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       tick16 = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       sel_fe = 1'b0;
    logic [7:0] own_addr = 8'h5A;
    logic [7:0] addr_mask = 8'hF0;
    logic [7:0] ctl_rdata, rx_data;
    logic       rx_bit9, ri, fe;

    int checks = 0;
    int fails = 0;
    logic [7:0] last_data = 8'h00;
    logic [1:0] tcnt = '0;

    mpuart_rx uut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick16(tick16),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .sel_fe(sel_fe),
        .own_addr(own_addr), .addr_mask(addr_mask), .ctl_rdata(ctl_rdata),
        .rx_data(rx_data), .rx_bit9(rx_bit9), .ri(ri), .fe(fe)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        tcnt   <= tcnt + 2'd1;
        tick16 <= (tcnt == 2'd3);
    end

    // {filter_en, data, bit9, stop, exp_ri, exp_fe}
    localparam logic [12:0] VEC [8] = '{
        {1'b0, 8'h3C, 1'b0, 1'b1, 1'b1, 1'b0},
        {1'b0, 8'hA5, 1'b1, 1'b1, 1'b1, 1'b0},
        {1'b1, 8'h51, 1'b1, 1'b1, 1'b1, 1'b0},
        {1'b1, 8'h33, 1'b1, 1'b1, 1'b0, 1'b0},
        {1'b1, 8'hFB, 1'b1, 1'b1, 1'b1, 1'b0},
        {1'b1, 8'h5A, 1'b0, 1'b1, 1'b0, 1'b0},
        {1'b0, 8'h81, 1'b0, 1'b0, 1'b1, 1'b1},
        {1'b1, 8'h12, 1'b1, 1'b0, 1'b0, 1'b1}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic ctl_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        sel_fe    = sel;
        ctl_wdata = d;
        ctl_wr    = 1'b1;
        @(negedge clk);
        ctl_wr    = 1'b0;
    endtask

    task automatic line_bit(input logic v);
        rx_line = v;
        repeat (64) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic b9, input logic stp);
        @(negedge clk);
        line_bit(1'b0);
        for (int i = 0; i < 8; i++) line_bit(d[i]);
        line_bit(b9);
        line_bit(stp);
        line_bit(1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ri", {7'd0, ri}, 8'h00);
        chk("R1 fe", {7'd0, fe}, 8'h00);
        chk("R1 rx_data", rx_data, 8'h00);
        chk("R1 rx_bit9", {7'd0, rx_bit9}, 8'h00);
        chk("R1 ctl_rdata", ctl_rdata, 8'h00);

        // vector table: R4 R5 R6 R8 R11
        for (int v = 0; v < 8; v++) begin
            logic       mp, b9, st, eri, efe;
            logic [7:0] d;
            {mp, d, b9, st, eri, efe} = VEC[v];
            ctl_write(1'b0, {2'b00, mp, 1'b1, 4'b0000});
            send_frame(d, b9, st);
            chk(mp ? "R6 ri" : "R5 ri", {7'd0, ri}, {7'd0, eri});
            chk("R8 fe", {7'd0, fe}, {7'd0, efe});
            if (eri) begin
                chk("R4 rx_data", rx_data, d);
                chk("R4 rx_bit9", {7'd0, rx_bit9}, {7'd0, b9});
                chk("R11 rdata", ctl_rdata, {2'b00, mp, 1'b1, 1'b0, b9, 1'b0, 1'b1});
                last_data = d;
            end else begin
                chk("R6 rx_data kept", rx_data, last_data);
            end
            ctl_write(1'b1, {2'b00, mp, 1'b1, 4'b0000});
            chk("R9 fe cleared", {7'd0, fe}, 8'h00);
        end

        // R9 sticky error, write of 1 does not clear
        ctl_write(1'b0, 8'h10);
        send_frame(8'h77, 1'b0, 1'b0);
        chk("R8 bad stop", {7'd0, fe}, 8'h01);
        ctl_write(1'b1, 8'h90);
        chk("R9 write one keeps fe", {7'd0, fe}, 8'h01);
        send_frame(8'h66, 1'b0, 1'b1);
        chk("R9 good frame keeps fe", {7'd0, fe}, 8'h01);
        chk("R4 good after bad", rx_data, 8'h66);
        // R10 select 0 write leaves fe
        ctl_write(1'b0, 8'h10);
        chk("R10 fe untouched", {7'd0, fe}, 8'h01);
        chk("R10 read mode bit", ctl_rdata, 8'h10);
        @(negedge clk); sel_fe = 1'b1;
        @(negedge clk);
        chk("R10 read fe", ctl_rdata, 8'h90);
        ctl_write(1'b1, 8'h10);
        chk("R9 cleared", {7'd0, fe}, 8'h00);
        ctl_write(1'b1, 8'h90);
        chk("R9 write one no set", {7'd0, fe}, 8'h00);
        // R10 mode bit storage
        ctl_write(1'b0, 8'h90);
        chk("R10 mode bit set", ctl_rdata, 8'h90);
        chk("R10 fe still 0", {7'd0, fe}, 8'h00);
        @(negedge clk); sel_fe = 1'b1;
        @(negedge clk);
        chk("R10 shows fe", ctl_rdata, 8'h10);
        ctl_write(1'b0, 8'h10);

        // R7 hold while ri set
        send_frame(8'h11, 1'b1, 1'b1);
        chk("R7 first", rx_data, 8'h11);
        send_frame(8'h22, 1'b0, 1'b1);
        chk("R7 data kept", rx_data, 8'h11);
        chk("R7 bit9 kept", {7'd0, rx_bit9}, 8'h01);
        chk("R7 ri kept", {7'd0, ri}, 8'h01);
        ctl_write(1'b0, 8'h10);
        chk("R11 ri cleared", {7'd0, ri}, 8'h00);

        // R3 start glitch aborts, then resync
        @(negedge clk); rx_line = 1'b0;
        repeat (12) @(negedge clk);
        rx_line = 1'b1;
        repeat (200) @(negedge clk);
        chk("R3 glitch ri", {7'd0, ri}, 8'h00);
        chk("R3 glitch fe", {7'd0, fe}, 8'h00);
        send_frame(8'h6B, 1'b0, 1'b1);
        chk("R3 resync", rx_data, 8'h6B);
        ctl_write(1'b0, 8'h10);

        // R2 receive disabled
        ctl_write(1'b0, 8'h00);
        send_frame(8'h44, 1'b1, 1'b1);
        chk("R2 disabled ri", {7'd0, ri}, 8'h00);
        chk("R2 disabled data", rx_data, 8'h6B);

        // R11 software write of ri
        ctl_write(1'b0, 8'h01);
        chk("R11 ri written", ctl_rdata, 8'h01);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule